// File: doc/BRIEF.md
# Programmable Video Timing Generator

This block produces horizontal sync, vertical sync and a data-enable strobe for a video panel, together with the pixel colour that is shown on each clock. Software sets the line period, the pulse widths and the active window through a write port. Horizontal timing comes from a counter that restarts on every line. Vertical timing does not count lines. It comes from a counter that runs across the whole frame in pixel clocks, so the vertical sync length and the vertical active window are written as absolute pixel-clock offsets within the frame.

Every register write lands in a shadow copy. The whole shadow set moves into the working set only at a frame boundary. While the engine is stopped, every clock counts as a frame boundary. Setting the enable bit therefore starts the engine on the next clock. Clearing it stops the engine only after the last pixel clock of the frame in progress. A monitor that waits for one frame boundary after clearing the bit knows that the stop has taken effect. The block also outputs the in-frame line count, a frame count, and the panel format word.

Top module: `vid_timing_engine`

## Requirements
- R1: After reset, hsync, vsync and de are 0, pix_out is 0, line_count and frame_count are 0, and panel_format is 0x2100.
- R2: Address 0 sets the line period in bits [15:0] and the hsync pulse width in bits [31:16]. While the engine runs, the clock at in-line position h shows hsync active when h is below the pulse width. The first position after start is h=0, and the outputs appear two clocks after the enable write.
- R3: Address 1 sets the frame period and address 2 sets the vsync length, both in pixel clocks. vsync is active while the frame offset f is below the vsync length. f and h both restart after frame period minus 1.
- R4: Address 3 sets the horizontal window, with the start in bits [15:0] and the end in bits [31:16]. Addresses 4 and 5 set the vertical start and end offsets. de is 1 only when both bounds hold, and both ends of each bound are included. de is 0 while the engine is stopped.
- R5: pix_out equals pix_data when de is 1 and pix_valid is 1. It equals the underflow colour (address 7, reset 0xFF) when de is 1 and pix_valid is 0. It equals the border colour (address 6, reset 0) when de is 0.
- R6: At address 8, bit 0 makes hsync active-low and bit 1 makes vsync active-low. While the engine is stopped, each sync output sits at its inactive level.
- R7: Bit 0 of address 11 enables the engine. Setting the bit while the engine is stopped starts it on the next clock. Clearing the bit while the engine runs takes effect only after the current frame's last pixel clock.
- R8: Writes made while a frame is running change nothing until the next frame boundary.
- R9: line_count gives the number of lines elapsed in the current frame and frame_count gives the number of frames elapsed. At address 10, bit 0 enables frame counting and bit 1 enables line counting. A counter whose bit is 0 is held at 0. Both counters are held at 0 while the engine is stopped.
- R10: Address 9 is the panel format word. Its colour-depth field sits in bits [5:0] (0x00, 0x15, 0x2A, 0x3F for 4, 5, 6, 8 bits). panel_format shows the written value from the next frame boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 32 | Register write data |
| pix_valid | input | 1 | Pixel data is available this clock |
| pix_data | input | CW (24) | Incoming pixel colour |
| hsync | output | 1 | Horizontal sync, programmed polarity |
| vsync | output | 1 | Vertical sync, programmed polarity |
| de | output | 1 | Data enable |
| pix_out | output | CW (24) | Colour shown this clock |
| line_count | output | FW (32) | Lines elapsed in the current frame |
| frame_count | output | FCW (16) | Frames elapsed |
| panel_format | output | 16 | Active panel format word |

## Verification
The bench uses the default widths and programs a small mode: a 10-clock line, a 60-clock frame, a 2-clock hsync pulse, a one-line vsync and an active window of 4 columns by 3 lines. With this mode a whole frame is only 60 clocks, so every pixel position of two full frames can be compared with values the bench computes arithmetically. That sweep covers the line and frame wrap, the inclusive window edges and an underflow pattern. The disable and the shadowed writes are issued in the middle of the second frame. The sweep then continues past the boundary to show that the running values hold to the last pixel and that the new polarity, window, border and counter settings appear only afterwards.

// File: rtl/vte_pkg.sv
package vte_pkg;
    localparam int REG_AW = 4;
    localparam logic [REG_AW-1:0] A_HCTRL  = 4'd0;
    localparam logic [REG_AW-1:0] A_FPER   = 4'd1;
    localparam logic [REG_AW-1:0] A_VLEN   = 4'd2;
    localparam logic [REG_AW-1:0] A_HWIN   = 4'd3;
    localparam logic [REG_AW-1:0] A_VSTART = 4'd4;
    localparam logic [REG_AW-1:0] A_VEND   = 4'd5;
    localparam logic [REG_AW-1:0] A_BORDER = 4'd6;
    localparam logic [REG_AW-1:0] A_UNDER  = 4'd7;
    localparam logic [REG_AW-1:0] A_POL    = 4'd8;
    localparam logic [REG_AW-1:0] A_FMT    = 4'd9;
    localparam logic [REG_AW-1:0] A_CNTEN  = 4'd10;
    localparam logic [REG_AW-1:0] A_ENABLE = 4'd11;
    localparam logic [15:0] FMT_RESET      = 16'h2100;
endpackage

// File: rtl/vte_regs.sv
module vte_regs
    import vte_pkg::*;
#(
    parameter int HW = 16,
    parameter int FW = 32,
    parameter int CW = 24,
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              frame_end_i,
    output logic              run_o,
    output logic [HW-1:0]     hper_o,
    output logic [HW-1:0]     hpw_o,
    output logic [HW-1:0]     hst_o,
    output logic [HW-1:0]     hend_o,
    output logic [FW-1:0]     fper_o,
    output logic [FW-1:0]     vlen_o,
    output logic [FW-1:0]     vst_o,
    output logic [FW-1:0]     vend_o,
    output logic [CW-1:0]     border_o,
    output logic [CW-1:0]     under_o,
    output logic [1:0]        pol_o,
    output logic [15:0]       fmt_o,
    output logic [1:0]        cnt_en_o
);
    localparam int HI_LSB = DW / 2;
    localparam logic [CW-1:0] UNDER_RESET = CW'(8'hFF);

    typedef struct packed {
        logic [HW-1:0] hper;
        logic [HW-1:0] hpw;
        logic [HW-1:0] hst;
        logic [HW-1:0] hend;
        logic [FW-1:0] fper;
        logic [FW-1:0] vlen;
        logic [FW-1:0] vst;
        logic [FW-1:0] vend;
        logic [CW-1:0] border;
        logic [CW-1:0] under;
        logic [1:0]    pol;
        logic [15:0]   fmt;
        logic [1:0]    cnt_en;
        logic          en;
    } cfg_t;

    typedef struct packed {
        cfg_t shd;
        cfg_t act;
    } state_t;

    state_t s_d, s_q;
    logic   boundary;

    function automatic cfg_t cfg_reset();
        cfg_t c;
        c        = '0;
        c.under  = UNDER_RESET;
        c.fmt    = FMT_RESET;
        return c;
    endfunction

    always_comb begin
        s_d      = s_q;
        boundary = !s_q.act.en || frame_end_i;
        if (wr_en) begin
            case (wr_addr)
                A_HCTRL: begin
                    s_d.shd.hper = wr_data[HW-1:0];
                    s_d.shd.hpw  = wr_data[HI_LSB +: HW];
                end
                A_FPER:   s_d.shd.fper   = wr_data[FW-1:0];
                A_VLEN:   s_d.shd.vlen   = wr_data[FW-1:0];
                A_HWIN: begin
                    s_d.shd.hst  = wr_data[HW-1:0];
                    s_d.shd.hend = wr_data[HI_LSB +: HW];
                end
                A_VSTART: s_d.shd.vst    = wr_data[FW-1:0];
                A_VEND:   s_d.shd.vend   = wr_data[FW-1:0];
                A_BORDER: s_d.shd.border = wr_data[CW-1:0];
                A_UNDER:  s_d.shd.under  = wr_data[CW-1:0];
                A_POL:    s_d.shd.pol    = wr_data[1:0];
                A_FMT:    s_d.shd.fmt    = wr_data[15:0];
                A_CNTEN:  s_d.shd.cnt_en = wr_data[1:0];
                A_ENABLE: s_d.shd.en     = wr_data[0];
                default: ;
            endcase
        end
        if (boundary) begin
            s_d.act = s_q.shd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.shd <= cfg_reset();
            s_q.act <= cfg_reset();
        end else begin
            s_q <= s_d;
        end
    end

    assign run_o    = s_q.act.en;
    assign hper_o   = s_q.act.hper;
    assign hpw_o    = s_q.act.hpw;
    assign hst_o    = s_q.act.hst;
    assign hend_o   = s_q.act.hend;
    assign fper_o   = s_q.act.fper;
    assign vlen_o   = s_q.act.vlen;
    assign vst_o    = s_q.act.vst;
    assign vend_o   = s_q.act.vend;
    assign border_o = s_q.act.border;
    assign under_o  = s_q.act.under;
    assign pol_o    = s_q.act.pol;
    assign fmt_o    = s_q.act.fmt;
    assign cnt_en_o = s_q.act.cnt_en;

    AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.act.en && !frame_end_i) |=> $stable(s_q.act)) else $error("active set changed mid-frame"); // R8

    AST_RUN_TO_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && !frame_end_i) |=> run_o) else $error("engine stopped mid-frame"); // R7
endmodule

// File: rtl/vte_count.sv
module vte_count #(
    parameter int HW  = 16,
    parameter int FW  = 32,
    parameter int FCW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run_i,
    input  logic [HW-1:0]  hper_i,
    input  logic [FW-1:0]  fper_i,
    input  logic [1:0]     cnt_en_i,
    output logic [HW-1:0]  hpos_o,
    output logic [FW-1:0]  fpos_o,
    output logic [FW-1:0]  line_o,
    output logic [FCW-1:0] frame_o,
    output logic           frame_end_o
);
    localparam logic [HW-1:0]  H_ONE = HW'(1);
    localparam logic [FW-1:0]  F_ONE = FW'(1);
    localparam logic [FCW-1:0] C_ONE = FCW'(1);

    typedef struct packed {
        logic [HW-1:0]  hpos;
        logic [FW-1:0]  fpos;
        logic [FW-1:0]  line;
        logic [FCW-1:0] frame;
    } cnt_t;

    cnt_t c_d, c_q;
    logic h_wrap, f_wrap;

    always_comb begin
        h_wrap = (c_q.hpos == hper_i - H_ONE);
        f_wrap = (c_q.fpos == fper_i - F_ONE);
        c_d    = '0;
        if (run_i) begin
            c_d.hpos = (h_wrap || f_wrap) ? '0 : c_q.hpos + H_ONE;
            c_d.fpos = f_wrap ? '0 : c_q.fpos + F_ONE;
            if (cnt_en_i[1]) begin
                if (f_wrap)      c_d.line = '0;
                else if (h_wrap) c_d.line = c_q.line + F_ONE;
                else             c_d.line = c_q.line;
            end
            if (cnt_en_i[0]) begin
                c_d.frame = f_wrap ? c_q.frame + C_ONE : c_q.frame;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign hpos_o      = c_q.hpos;
    assign fpos_o      = c_q.fpos;
    assign line_o      = c_q.line;
    assign frame_o     = c_q.frame;
    assign frame_end_o = run_i && f_wrap;

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (c_q.fpos == '0 && c_q.hpos == '0 && c_q.line == '0)) else $error("counters moved while stopped"); // R9

    AST_HPOS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && hper_i != '0 && c_q.hpos < hper_i) |=> (c_q.hpos <= hper_i || !run_i)) else $error("line position overran"); // R2

    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end_o |=> c_q.fpos == '0) else $error("frame offset did not wrap"); // R3

    AST_LINE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en_i[1] |=> c_q.line == '0) else $error("line counter ran while gated"); // R9
endmodule

// File: rtl/vte_syncgen.sv
module vte_syncgen #(
    parameter int HW = 16,
    parameter int FW = 32,
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic [HW-1:0] hpos_i,
    input  logic [FW-1:0] fpos_i,
    input  logic [HW-1:0] hpw_i,
    input  logic [HW-1:0] hst_i,
    input  logic [HW-1:0] hend_i,
    input  logic [FW-1:0] vlen_i,
    input  logic [FW-1:0] vst_i,
    input  logic [FW-1:0] vend_i,
    input  logic [CW-1:0] border_i,
    input  logic [CW-1:0] under_i,
    input  logic [1:0]    pol_i,
    input  logic          pix_valid_i,
    input  logic [CW-1:0] pix_data_i,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          de_o,
    output logic [CW-1:0] pix_o
);
    typedef struct packed {
        logic          hs;
        logic          vs;
        logic          de;
        logic [CW-1:0] pix;
    } out_t;

    out_t o_d, o_q;
    logic h_act, v_act, h_win, v_win;

    always_comb begin
        h_act   = run_i && (hpos_i < hpw_i);
        v_act   = run_i && (fpos_i < vlen_i);
        h_win   = (hpos_i >= hst_i) && (hpos_i <= hend_i);
        v_win   = (fpos_i >= vst_i) && (fpos_i <= vend_i);
        o_d.hs  = h_act ^ pol_i[0];
        o_d.vs  = v_act ^ pol_i[1];
        o_d.de  = run_i && h_win && v_win;
        if (!o_d.de)          o_d.pix = border_i;
        else if (pix_valid_i) o_d.pix = pix_data_i;
        else                  o_d.pix = under_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign hsync_o = o_q.hs;
    assign vsync_o = o_q.vs;
    assign de_o    = o_q.de;
    assign pix_o   = o_q.pix;

    AST_DE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !de_o) else $error("de while stopped"); // R4

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (hsync_o == $past(pol_i[0]) && vsync_o == $past(pol_i[1]))) else $error("sync not inactive while stopped"); // R6

    AST_BORDER_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !o_d.de |=> pix_o == $past(border_i)) else $error("border colour missing"); // R5
endmodule

// File: rtl/vid_timing_engine.sv
module vid_timing_engine
    import vte_pkg::*;
#(
    parameter int HW  = 16,
    parameter int FW  = 32,
    parameter int CW  = 24,
    parameter int FCW = 16,
    parameter int DW  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              pix_valid,
    input  logic [CW-1:0]     pix_data,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic [CW-1:0]     pix_out,
    output logic [FW-1:0]     line_count,
    output logic [FCW-1:0]    frame_count,
    output logic [15:0]       panel_format
);
    logic          run, frame_end;
    logic [HW-1:0] hper, hpw, hst, hend, hpos;
    logic [FW-1:0] fper, vlen, vst, vend, fpos;
    logic [CW-1:0] border, under;
    logic [1:0]    pol, cnt_en;

    vte_regs #(.HW(HW), .FW(FW), .CW(CW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .frame_end_i(frame_end), .run_o(run),
        .hper_o(hper), .hpw_o(hpw), .hst_o(hst), .hend_o(hend),
        .fper_o(fper), .vlen_o(vlen), .vst_o(vst), .vend_o(vend),
        .border_o(border), .under_o(under), .pol_o(pol),
        .fmt_o(panel_format), .cnt_en_o(cnt_en)
    );

    vte_count #(.HW(HW), .FW(FW), .FCW(FCW)) u_count (
        .clk(clk), .rst_n(rst_n), .run_i(run), .hper_i(hper), .fper_i(fper),
        .cnt_en_i(cnt_en), .hpos_o(hpos), .fpos_o(fpos),
        .line_o(line_count), .frame_o(frame_count), .frame_end_o(frame_end)
    );

    vte_syncgen #(.HW(HW), .FW(FW), .CW(CW)) u_sync (
        .clk(clk), .rst_n(rst_n), .run_i(run), .hpos_i(hpos), .fpos_i(fpos),
        .hpw_i(hpw), .hst_i(hst), .hend_i(hend),
        .vlen_i(vlen), .vst_i(vst), .vend_i(vend),
        .border_i(border), .under_i(under), .pol_i(pol),
        .pix_valid_i(pix_valid), .pix_data_i(pix_data),
        .hsync_o(hsync), .vsync_o(vsync), .de_o(de), .pix_o(pix_out)
    );
endmodule

// File: tb/vid_timing_engine_test.sv
`timescale 1ns/1ps
module vid_timing_engine_test;
    localparam int HT = 10, HPW = 2, FP = 60, VLEN = 10, VST = 20, VEND = 49;

    logic        clk = 0, rst_n = 0;
    logic        wr_en = 0;
    logic [3:0]  wr_addr = 0;
    logic [31:0] wr_data = 0;
    logic        pix_valid = 0;
    logic [23:0] pix_data = 0;
    logic        hsync, vsync, de;
    logic [23:0] pix_out;
    logic [31:0] line_count;
    logic [15:0] frame_count;
    logic [15:0] panel_format;

    int total = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    vid_timing_engine uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pix_valid(pix_valid), .pix_data(pix_data),
        .hsync(hsync), .vsync(vsync), .de(de), .pix_out(pix_out),
        .line_count(line_count), .frame_count(frame_count), .panel_format(panel_format)
    );

    task automatic chk(string req, string what, longint act, longint exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    function automatic bit pv(int k);  return (k % 5) != 2;          endfunction
    function automatic logic [23:0] pd(int k); return 24'h0A0000 + 24'(k); endfunction

    // Sweep from enable; stop_k: first sample index that is idle (or -1).
    task automatic sweep(int n, int stop_k, int hs0, int he0, logic [1:0] pol,
                         logic [23:0] bord, bit lines_on, logic [1:0] pol_idle,
                         logic [23:0] bord_idle, bit mid_writes);
        @(negedge clk);
        pix_valid = pv(0); pix_data = pd(0);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (stop_k >= 0 && k >= stop_k) begin
                chk("R6 R7", "hsync idle", hsync, pol_idle[0]);
                chk("R6 R7", "vsync idle", vsync, pol_idle[1]);
                chk("R4 R7", "de idle", de, 0);
                chk("R5 R8", "pix idle", pix_out, bord_idle);
                chk("R9", "line idle", line_count, 0);
                chk("R9", "frame idle", frame_count, 0);
            end else begin
                int h = k % HT, f = k % FP, p = k + 1;
                bit e = (h >= hs0) && (h <= he0) && (f >= VST) && (f <= VEND);
                chk("R2 R6", "hsync", hsync, (h < HPW) ^ pol[0]);
                chk("R3 R6", "vsync", vsync, (f < VLEN) ^ pol[1]);
                chk("R4 R8", "de", de, e);
                chk("R5", "pix", pix_out, !e ? bord : (pv(k) ? pd(k) : 24'hFF));
                chk("R9", "line", line_count, lines_on ? (p % FP) / HT : 0);
                chk("R9", "frame", frame_count, p / FP);
            end
            if (mid_writes) begin
                wr_en = 1;
                case (k)
                    70: begin wr_addr = 11; wr_data = 0; end
                    71: begin wr_addr = 8;  wr_data = 3; end
                    72: begin wr_addr = 3;  wr_data = {16'd3, 16'd2}; end
                    73: begin wr_addr = 6;  wr_data = 32'h123; end
                    74: begin wr_addr = 10; wr_data = 1; end
                    default: wr_en = 0;
                endcase
            end
            pix_valid = pv(k + 1); pix_data = pd(k + 1);
        end
        wr_en = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL R7 watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "hsync", hsync, 0);
        chk("R1", "vsync", vsync, 0);
        chk("R1", "de", de, 0);
        chk("R1", "pix", pix_out, 0);
        chk("R1", "line", line_count, 0);
        chk("R1", "frame", frame_count, 0);
        chk("R1 R10", "format", panel_format, 16'h2100);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "hsync after release", hsync, 0);

        wr(0, {16'd2, 16'd10});
        wr(1, FP);
        wr(2, VLEN);
        wr(3, {16'd7, 16'd4});
        wr(4, VST);
        wr(5, VEND);
        wr(10, 3);
        wr(9, 32'h212A);
        @(negedge clk);
        chk("R10", "format 6bpc", panel_format, 16'h212A);
        chk("R7", "idle before enable", de, 0);

        // Run 1: two frames, disable and shadowed writes mid second frame.
        wr(11, 1);
        sweep(130, 120, 4, 7, 2'b00, 24'h0, 1, 2'b11, 24'h123, 1);

        // Run 2: new settings from the shadow set, lines gated off.
        wr(11, 1);
        sweep(70, -1, 2, 3, 2'b11, 24'h123, 0, 2'b11, 24'h123, 0);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule